// File: doc/BRIEF.md
# Dual Page Buffer Unit

This block holds the two byte-wide staging buffers that sit between a serial flash controller's host side and its flash array. Each buffer is 264 bytes deep, which is not a power of two, and is addressed with 9 bits. The host opens a transaction with a start pulse that carries a buffer select and a start byte. It then streams bytes in with write strobes or pulls them out with read strobes. An internal pointer advances after every accepted byte and wraps from byte 263 back to byte 0.

An array engine serves the flash side. A start pulse with an operation kind and a buffer select claims one buffer. The engine then takes exactly 264 bytes from a byte-streaming array port, gated by a valid strobe. A transfer writes those bytes into the buffer in order. A compare checks them against the buffer contents and leaves a single mismatch flag. While one buffer is claimed, the host can still read and write the other one without delay. Host accesses aimed at the claimed buffer are dropped and answered with an error pulse.

The host port runs a two-state machine: HP_CLOSED → HP_OPEN on the start pulse, and HP_OPEN → HP_OPEN again on every later start. The engine runs four states. ENG_IDLE → ENG_LOAD on a start with kind 0 (transfer). ENG_IDLE → ENG_CMP on a start with kind 1 (compare). ENG_LOAD or ENG_CMP → ENG_FINISH when byte 263 is accepted. ENG_FINISH → ENG_IDLE unconditionally.

Top module: `dual_page_buffer`

## Requirements
- R1: After reset, `buf_busy` is 0, `cmp_miss` is 0, and `host_rvalid`, `host_err` and `op_done` are low. Read or write strobes given before the first `host_start` produce neither data nor an error.
- R2: A `host_start` sets the pointer to `host_addr` in the buffer `host_buf`. Each `host_wr` stores `host_wdata` at the pointer and advances it, and the pointer continues at byte 0 after byte 263.
- R3: Each `host_rd` returns the byte at the pointer on `host_rdata`, with `host_rvalid` high in the cycle after the strobe. The pointer then advances with the same wrap as in R2.
- R4: A start address from 264 to 511 places the pointer at byte 0, and the pointer never holds a value above 263.
- R5: An `op_start` with `op_kind`=0 makes `buf_busy[op_buf]` high from the next cycle. The next 264 bytes seen with `arr_vld` high are written into that buffer at bytes 0 to 263 in order. Cycles with `arr_vld` low are skipped.
- R6: An `op_start` with `op_kind`=1 compares the next 264 valid array bytes with bytes 0 to 263 of buffer `op_buf`. `cmp_miss` becomes 0 if every bit matched and 1 otherwise, and changes only when a compare completes.
- R7: A host read or write to the buffer currently in use by the array engine is ignored. It leaves the buffer contents and the pointer unchanged, gives no `host_rvalid`, and raises `host_err` for one cycle in the cycle after the strobe.
- R8: Host reads and writes to the buffer not in use by the array engine are served exactly as in R2 and R3 while the operation runs.
- R9: An `op_start` that arrives while an operation is in progress is ignored.
- R10: `op_done` is high for exactly one cycle, the cycle after the one that accepted byte 263. `buf_busy` is still high in that cycle and drops in the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_start | input | 1 | Opens a host transaction |
| host_buf | input | 1 | Buffer select captured with host_start |
| host_addr | input | 9 | Start byte captured with host_start |
| host_wr | input | 1 | Write one byte at the pointer |
| host_wdata | input | 8 | Byte to write |
| host_rd | input | 1 | Read one byte at the pointer |
| host_rdata | output | 8 | Read byte, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid pulse |
| host_err | output | 1 | Access rejected because the buffer is in use |
| op_start | input | 1 | Starts an array operation |
| op_kind | input | 1 | 0 = page to buffer transfer, 1 = page compare |
| op_buf | input | 1 | Buffer used by the array operation |
| arr_vld | input | 1 | Array byte valid |
| arr_data | input | 8 | Array byte stream, page byte 0 first |
| buf_busy | output | 2 | Per-buffer in-use flag |
| op_done | output | 1 | Operation completion pulse |
| cmp_miss | output | 1 | Result of the last compare, 1 = mismatch |

## Verification
The assertions rely on a few properties of the inputs. The host never asserts read and write in the same cycle, and never combines them with a start pulse. The array side sends no valid bytes while the engine is idle. Start addresses are always below 512, so they fit the 9-bit field. The bench drives every input at the falling clock edge. Its tasks issue one host action per cycle, and its array stream begins only in the cycle after an accepted operation start. Idle gaps appear in the stream at fixed positions, and the bench fires a second operation start in the middle of a run. Together these exercise the cases the engine must skip or ignore, while keeping the inputs within the assumptions above.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_LOAD,
        ENG_CMP,
        ENG_FINISH
    } eng_state_t;

    typedef enum logic {
        HP_CLOSED,
        HP_OPEN
    } host_state_t;

endpackage

// File: rtl/pgbuf_ram.sv
module pgbuf_ram #(
    parameter int DEPTH = 264,
    parameter int AW    = 9,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];

endmodule

// File: rtl/pgbuf_host_port.sv
module pgbuf_host_port
    import pgbuf_pkg::*;
#(
    parameter int NBUF  = 2,
    parameter int DEPTH = 264,
    parameter int AW    = 9,
    parameter int DW    = 8,
    parameter int SEL_W = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [SEL_W-1:0]          sel,
    input  logic [AW-1:0]             addr,
    input  logic                      wr,
    input  logic [DW-1:0]             wdata,
    input  logic                      rd,
    input  logic [NBUF-1:0]           busy,
    input  logic [NBUF-1:0][DW-1:0]   mem_q,
    output logic [AW-1:0]             ptr,
    output logic [NBUF-1:0]           we,
    output logic [DW-1:0]             rdata,
    output logic                      rvalid,
    output logic                      err
);

    localparam logic [AW-1:0] LAST_A  = AW'(DEPTH - 1);
    localparam logic [AW-1:0] DEPTH_A = AW'(DEPTH);

    host_state_t         state_q, state_d;
    logic [SEL_W-1:0]    cur_q;
    logic [AW-1:0]       ptr_q;
    logic [AW-1:0]       ptr_inc;
    logic                access;
    logic                blocked;
    logic                accept;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HP_CLOSED;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and strobes
    always_comb begin
        state_d = state_q;
        access  = 1'b0;
        unique case (state_q)
            HP_CLOSED: begin
                if (start) state_d = HP_OPEN;
            end
            HP_OPEN: begin
                access = !start && (wr || rd);
            end
        endcase
        blocked = busy[cur_q];
        accept  = access && !blocked;
        ptr_inc = (ptr_q == LAST_A) ? '0 : ptr_q + 1'b1;
        we      = '0;
        if (accept && wr) begin
            we[cur_q] = 1'b1;
        end
    end

    // pointer and read datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            ptr_q  <= '0;
            rdata  <= '0;
            rvalid <= 1'b0;
            err    <= 1'b0;
        end else begin
            rvalid <= 1'b0;
            err    <= access && blocked;
            if (start) begin
                cur_q <= sel;
                ptr_q <= (addr >= DEPTH_A) ? '0 : addr;
            end else if (accept) begin
                ptr_q <= ptr_inc;
                if (!wr) begin
                    rdata  <= mem_q[cur_q];
                    rvalid <= 1'b1;
                end
            end
        end
    end

    assign ptr = ptr_q;

    // R4
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q < DEPTH_A);

    // R7
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !rvalid);

endmodule

// File: rtl/pgbuf_engine.sv
module pgbuf_engine
    import pgbuf_pkg::*;
#(
    parameter int NBUF  = 2,
    parameter int DEPTH = 264,
    parameter int AW    = 9,
    parameter int DW    = 8,
    parameter int SEL_W = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      op_start,
    input  logic                      op_kind,
    input  logic [SEL_W-1:0]          op_buf,
    input  logic                      arr_vld,
    input  logic [DW-1:0]             arr_data,
    input  logic [NBUF-1:0][DW-1:0]   mem_q,
    output logic [AW-1:0]             cnt,
    output logic [NBUF-1:0]           we,
    output logic [NBUF-1:0]           busy,
    output logic                      done,
    output logic                      miss
);

    localparam logic [AW-1:0] LAST_A  = AW'(DEPTH - 1);
    localparam logic [AW-1:0] DEPTH_A = AW'(DEPTH);

    eng_state_t          state_q, state_d;
    logic [AW-1:0]       cnt_q;
    logic [SEL_W-1:0]    buf_q;
    logic                acc_q;
    logic                last_byte;
    logic                diff;

    assign last_byte = arr_vld && (cnt_q == LAST_A);
    assign diff      = (arr_data != mem_q[buf_q]);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE:   if (op_start) state_d = op_kind ? ENG_CMP : ENG_LOAD;
            ENG_LOAD:   if (last_byte) state_d = ENG_FINISH;
            ENG_CMP:    if (last_byte) state_d = ENG_FINISH;
            ENG_FINISH: state_d = ENG_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy = '0;
        we   = '0;
        done = 1'b0;
        unique case (state_q)
            ENG_IDLE: ;
            ENG_LOAD: begin
                busy[buf_q] = 1'b1;
                we[buf_q]   = arr_vld;
            end
            ENG_CMP: busy[buf_q] = 1'b1;
            ENG_FINISH: begin
                busy[buf_q] = 1'b1;
                done        = 1'b1;
            end
        endcase
    end

    // counter and compare datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            buf_q <= '0;
            acc_q <= 1'b0;
            miss  <= 1'b0;
        end else begin
            if (state_q == ENG_IDLE) begin
                if (op_start) begin
                    buf_q <= op_buf;
                    cnt_q <= '0;
                    acc_q <= 1'b0;
                end
            end else if ((state_q == ENG_LOAD || state_q == ENG_CMP) && arr_vld) begin
                cnt_q <= last_byte ? '0 : cnt_q + 1'b1;
                if (state_q == ENG_CMP) begin
                    acc_q <= acc_q | diff;
                    if (last_byte) miss <= acc_q | diff;
                end
            end
        end
    end

    assign cnt = cnt_q;

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < DEPTH_A);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miss) |-> done);

endmodule

// File: rtl/dual_page_buffer.sv
module dual_page_buffer #(
    parameter int NBUF  = 2,
    parameter int DEPTH = 264,
    parameter int AW    = 9,
    parameter int DW    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_start,
    input  logic [$clog2(NBUF)-1:0]   host_buf,
    input  logic [AW-1:0]             host_addr,
    input  logic                      host_wr,
    input  logic [DW-1:0]             host_wdata,
    input  logic                      host_rd,
    output logic [DW-1:0]             host_rdata,
    output logic                      host_rvalid,
    output logic                      host_err,
    input  logic                      op_start,
    input  logic                      op_kind,
    input  logic [$clog2(NBUF)-1:0]   op_buf,
    input  logic                      arr_vld,
    input  logic [DW-1:0]             arr_data,
    output logic [NBUF-1:0]           buf_busy,
    output logic                      op_done,
    output logic                      cmp_miss
);

    localparam int SEL_W = $clog2(NBUF);

    logic [AW-1:0]             host_ptr;
    logic [AW-1:0]             eng_cnt;
    logic [NBUF-1:0]           host_we;
    logic [NBUF-1:0]           eng_we;
    logic [NBUF-1:0][DW-1:0]   q_host;
    logic [NBUF-1:0][DW-1:0]   q_eng;

    pgbuf_host_port #(
        .NBUF(NBUF), .DEPTH(DEPTH), .AW(AW), .DW(DW), .SEL_W(SEL_W)
    ) u_host (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (host_start),
        .sel    (host_buf),
        .addr   (host_addr),
        .wr     (host_wr),
        .wdata  (host_wdata),
        .rd     (host_rd),
        .busy   (buf_busy),
        .mem_q  (q_host),
        .ptr    (host_ptr),
        .we     (host_we),
        .rdata  (host_rdata),
        .rvalid (host_rvalid),
        .err    (host_err)
    );

    pgbuf_engine #(
        .NBUF(NBUF), .DEPTH(DEPTH), .AW(AW), .DW(DW), .SEL_W(SEL_W)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_start (op_start),
        .op_kind  (op_kind),
        .op_buf   (op_buf),
        .arr_vld  (arr_vld),
        .arr_data (arr_data),
        .mem_q    (q_eng),
        .cnt      (eng_cnt),
        .we       (eng_we),
        .busy     (buf_busy),
        .done     (op_done),
        .miss     (cmp_miss)
    );

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        logic          wen;
        logic [AW-1:0] wa;
        logic [DW-1:0] wd;

        assign wen = host_we[g] | eng_we[g];
        assign wa  = eng_we[g] ? eng_cnt  : host_ptr;
        assign wd  = eng_we[g] ? arr_data : host_wdata;

        pgbuf_ram #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ram (
            .clk     (clk),
            .we      (wen),
            .waddr   (wa),
            .wdata   (wd),
            .raddr_a (host_ptr),
            .rdata_a (q_host[g]),
            .raddr_b (eng_cnt),
            .rdata_b (q_eng[g])
        );
    end

    // R8
    wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we & eng_we) == '0);

endmodule

// File: tb/sim_dual_page_buffer.sv
module sim_dual_page_buffer;

    localparam int DEPTH = 264;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       host_start, host_buf, host_wr, host_rd;
    logic [8:0] host_addr;
    logic [7:0] host_wdata, host_rdata;
    logic       host_rvalid, host_err;
    logic       op_start, op_kind, op_buf, arr_vld;
    logic [7:0] arr_data;
    logic [1:0] buf_busy;
    logic       op_done, cmp_miss;

    always #10 clk = ~clk;

    dual_page_buffer u0 (
        .clk(clk), .rst_n(rst_n),
        .host_start(host_start), .host_buf(host_buf), .host_addr(host_addr),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .host_err(host_err),
        .op_start(op_start), .op_kind(op_kind), .op_buf(op_buf),
        .arr_vld(arr_vld), .arr_data(arr_data),
        .buf_busy(buf_busy), .op_done(op_done), .cmp_miss(cmp_miss)
    );

    int         checks = 0;
    int         errors = 0;
    int         done_cnt = 0;
    int         mbuf = 0;
    int         mptr = 0;
    logic [7:0] model [2][DEPTH];
    logic [7:0] expq [$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] page_byte(input int i, input int seed);
        return 8'((i * 7 + seed * 13) & 255);
    endfunction

    // monitor: pops expected read bytes as the design returns them
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R3 unexpected read data", int'(host_rdata), -1);
            end else begin
                chk(host_rdata == expq[0], "R3 read data", int'(host_rdata), int'(expq[0]));
                void'(expq.pop_front());
            end
        end
        if (rst_n && op_done) done_cnt++;
    end

    task automatic h_start(input int b, input int a);
        host_start = 1'b1;
        host_buf   = b[0];
        host_addr  = a[8:0];
        @(negedge clk);
        host_start = 1'b0;
        mbuf = b;
        mptr = (a >= DEPTH) ? 0 : a;
    endtask

    task automatic h_wr(input logic [7:0] d, input bit exp_err, input string req);
        host_wr    = 1'b1;
        host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        chk(host_err == exp_err, req, int'(host_err), int'(exp_err));
        if (!exp_err) begin
            model[mbuf][mptr] = d;
            mptr = (mptr == DEPTH - 1) ? 0 : mptr + 1;
        end
    endtask

    task automatic h_rd(input bit exp_err, input string req);
        if (!exp_err) begin
            expq.push_back(model[mbuf][mptr]);
            mptr = (mptr == DEPTH - 1) ? 0 : mptr + 1;
        end
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        chk(host_err == exp_err, req, int'(host_err), int'(exp_err));
    endtask

    task automatic stream(input bit kind, input int b, input int seed, input int flip,
                          input bit exp_miss);
        logic [7:0] d;
        done_cnt = 0;
        op_start = 1'b1;
        op_kind  = kind;
        op_buf   = b[0];
        @(negedge clk);
        op_start = 1'b0;
        chk(buf_busy == 2'(1 << b), "R5 busy after start", int'(buf_busy), 1 << b);
        for (int i = 0; i < DEPTH; i++) begin
            if (i % 7 == 3) begin
                arr_vld  = 1'b0;
                arr_data = 8'hEE;
                @(negedge clk);
            end
            d = page_byte(i, seed) ^ ((i == flip) ? 8'h10 : 8'h00);
            arr_vld  = 1'b1;
            arr_data = d;
            if (i == 100) begin
                op_start = 1'b1;
                op_kind  = ~kind;
                op_buf   = ~b[0];
            end
            @(negedge clk);
            op_start = 1'b0;
            if (i == 100) begin
                chk(buf_busy == 2'(1 << b), "R9 second start ignored", int'(buf_busy), 1 << b);
            end
            if (kind == 1'b0) model[b][i] = d;
        end
        arr_vld = 1'b0;
        chk(op_done == 1'b1, "R10 done after last byte", int'(op_done), 1);
        chk(buf_busy == 2'(1 << b), "R10 busy during done", int'(buf_busy), 1 << b);
        if (kind) chk(cmp_miss == exp_miss, "R6 compare result", int'(cmp_miss), int'(exp_miss));
        @(negedge clk);
        chk(buf_busy == 2'b00, "R10 busy cleared", int'(buf_busy), 0);
        chk(done_cnt == 1, "R10 single done pulse", done_cnt, 1);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        host_start = 1'b0; host_buf = 1'b0; host_addr = '0;
        host_wr = 1'b0; host_wdata = '0; host_rd = 1'b0;
        op_start = 1'b0; op_kind = 1'b0; op_buf = 1'b0;
        arr_vld = 1'b0; arr_data = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(buf_busy == 2'b00, "R1 busy reset", int'(buf_busy), 0);
        chk(cmp_miss == 1'b0, "R1 cmp_miss reset", int'(cmp_miss), 0);
        chk(!host_rvalid && !host_err && !op_done, "R1 pulses low",
            int'({host_rvalid, host_err, op_done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 access before any start is ignored
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        chk(!host_rvalid && !host_err, "R1 access before start",
            int'({host_rvalid, host_err}), 0);

        // R2 write with wrap, R3 read back with wrap
        h_start(0, 260);
        for (int k = 0; k < 12; k++) h_wr(8'(8'hA0 + k), 1'b0, "R2 write");
        h_start(0, 260);
        for (int k = 0; k < 10; k++) h_rd(1'b0, "R3 read");
        h_start(0, 263);
        h_rd(1'b0, "R3 read last byte");
        h_rd(1'b0, "R3 read wrapped byte");

        // R4 out-of-range start addresses
        h_start(1, 300);
        for (int k = 0; k < 3; k++) h_wr(8'(8'h30 + k), 1'b0, "R4 write");
        h_start(1, 0);
        for (int k = 0; k < 3; k++) h_rd(1'b0, "R4 read");
        h_start(1, 511);
        h_wr(8'h5A, 1'b0, "R4 write from 511");
        h_start(1, 0);
        h_rd(1'b0, "R4 byte 0 after 511");

        // R5 transfer into buffer 1 while R8 traffic hits buffer 0 and R7 hits buffer 1
        fork
            stream(1'b0, 1, 5, -1, 1'b0);
            begin
                repeat (20) @(negedge clk);
                h_start(0, 10);
                for (int k = 0; k < 4; k++) h_wr(8'(8'h60 + k), 1'b0, "R8 write other buffer");
                h_start(0, 10);
                for (int k = 0; k < 4; k++) h_rd(1'b0, "R8 read other buffer");
                h_start(1, 5);
                h_wr(8'h77, 1'b1, "R7 write to busy buffer");
                h_rd(1'b1, "R7 read from busy buffer");
            end
        join
        // R7 pointer and contents untouched: next read gives page byte 5
        h_rd(1'b0, "R7 pointer kept");
        h_start(1, 0);
        for (int k = 0; k < DEPTH; k++) h_rd(1'b0, "R5 transferred page");

        // R6 compare: match, mismatch in last byte, hold, match again
        stream(1'b1, 1, 5, -1, 1'b0);
        stream(1'b1, 1, 5, 263, 1'b1);
        h_start(0, 0);
        for (int k = 0; k < 5; k++) h_wr(8'(k), 1'b0, "R6 traffic");
        chk(cmp_miss == 1'b1, "R6 result held", int'(cmp_miss), 1);
        stream(1'b1, 1, 5, -1, 1'b0);

        repeat (3) @(negedge clk);
        chk(expq.size() == 0, "R3 all reads returned", expq.size(), 0);
        finish_run();
    end

endmodule